// File: doc/BRIEF.md
# Program and Data Address Map Decoder

This block classifies every address issued by a small processor core. Each cycle it looks at the current instruction-fetch address and the current data-space address, then names the single target that owns each one. A fetch goes to the on-chip program ROM or to the external multiplexed bus. A data access goes to the on-chip 1 KB SRAM, to a read-only lock-status byte, to the external bus, or to nowhere (a reserved hole). An external-access pin can force every fetch off-chip. The strobe enable for the external program memory is active low.

Two fields set the map, and software may change both at run time through a small register write port. The first is a 3-bit ROM-size code that fixes the top of the on-chip program space. The second is a 2-bit data-enable code that opens or closes the internal SRAM window. The ROM-size field is protected. It accepts a write only inside a short window that a two-step unlock sequence opens on the unlock register. The decode itself is purely combinational on the current addresses and the registered fields, so a field change affects the cycle after the write edge. The block models no memory arrays and no bus timing.

Top module: `mem_map_decoder`

## Requirements
- R1: The ROM-size code sets the on-chip ROM limit: 000 gives 0 bytes, 001 gives 1 KB, 010 gives 2 KB, 011 gives 4 KB, 100 gives 8 KB and 101 gives 16 KB. With `ext_access_n` high, a fetch address below the limit asserts `fetch_int` only.
- R2: After reset the ROM-size code is 101, so 0000h..3FFFh fetch on-chip and 4000h fetches externally. The data-enable code is 00.
- R3: A fetch address at or above the limit asserts `fetch_ext` and drives `psen_n` low. An on-chip fetch holds `psen_n` high.
- R4: While `ext_access_n` is low, every fetch is external, whatever the ROM-size code.
- R5: With data-enable code 00, every data address from 0000h to FFFFh asserts `data_ext`.
- R6: With data-enable code 01, 0000h..03FFh asserts `data_sram` and 0400h..FFFFh asserts `data_ext`.
- R7: With data-enable code 11, 0000h..03FFh asserts `data_sram`. FFFCh asserts `data_lock`, and `lock_byte` then reads {5'b0, lock_bits}. Every other address asserts `data_none`. `lock_byte` is 00h whenever `data_lock` is low.
- R8: The data-enable field is written with `reg_sel`=10, taking `reg_wdata[1:0]`, and needs no unlock. A write of the reserved code 10 is ignored and the previous code stays.
- R9: The ROM-size field is written with `reg_sel`=01, taking `reg_wdata[2:0]`. The write takes effect only inside the unlock window. The window opens when AAh is written to the unlock register (`reg_sel`=00) and 55h is written there in the very next cycle. It covers the 3 cycles after the 55h write. It closes after one ROM-size write, after any other unlock-register write, or on expiry. In every other case the field is unchanged.
- R10: A ROM-size write of reserved code 110 or 111 is ignored even inside an open window, and it still closes the window.
- R11: Exactly one fetch target and exactly one data target are asserted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_access_n | input | 1 | Low forces all fetches external |
| fetch_addr | input | 16 | Instruction fetch address |
| data_addr | input | 16 | Data-space address |
| lock_bits | input | 3 | Programmed lock bits, reported at FFFCh |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 00 unlock, 01 ROM size, 10 data enable, 11 unused |
| reg_wdata | input | 8 | Register write data |
| fetch_int | output | 1 | Fetch targets on-chip ROM |
| fetch_ext | output | 1 | Fetch targets external bus |
| psen_n | output | 1 | External program strobe enable, active low |
| data_sram | output | 1 | Data access targets on-chip SRAM |
| data_ext | output | 1 | Data access targets external bus |
| data_lock | output | 1 | Data access reads the lock-status byte |
| data_none | output | 1 | Data address is a reserved hole, no access |
| lock_byte | output | 8 | Lock-status byte value |

## Verification
The assertions assume that `reg_sel` and `reg_wdata` are known whenever `reg_wr` is high. They also assume that the addresses are driven to known values after reset, because the target one-hot checks read them every cycle. The stimulus changes every input only on the falling clock edge and never leaves a port undriven. It draws its addresses from the region boundaries (03FFh/0400h, each ROM limit minus one and the limit itself, FFFBh..FFFDh) as well as at random. This keeps every compare on a settled value in the middle of the cycle.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    SEL_UNLOCK = 2'b00,
    SEL_ROM    = 2'b01,
    SEL_DME    = 2'b10,
    SEL_NONE   = 2'b11
  } reg_sel_e;

  localparam logic [2:0] ROM_CODE_MAX   = 3'd5;
  localparam logic [2:0] ROM_CODE_RESET = 3'd5;
  localparam logic [1:0] DME_OFF        = 2'b00;
  localparam logic [1:0] DME_SRAM_EXT   = 2'b01;
  localparam logic [1:0] DME_RSVD       = 2'b10;
  localparam logic [1:0] DME_SRAM_STAT  = 2'b11;

  // Limit in bytes: code 0 -> 0, code c -> 2^(KB_SHIFT + c - 1)
  function automatic logic [ADDR_W:0] rom_limit(input logic [2:0] code, input int kb_shift);
    logic [ADDR_W:0] lim;
    lim = '0;
    if (code != 3'd0 && code <= ROM_CODE_MAX)
      lim = (ADDR_W+1)'(1) << (kb_shift + int'(code) - 1);
    return lim;
  endfunction
endpackage

// File: rtl/mmd_timed_access.sv
module mmd_timed_access
  import mmd_pkg::*;
#(
  parameter int          WIN_CYCLES = 3,
  parameter logic [7:0]  KEY_FIRST  = 8'hAA,
  parameter logic [7:0]  KEY_SECOND = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic       win_open
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unlock_wr, rom_wr;

  assign unlock_wr = wr && (sel == SEL_UNLOCK);
  assign rom_wr    = wr && (sel == SEL_ROM);
  assign win_open  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= unlock_wr && (wdata == KEY_FIRST);
      if (unlock_wr && armed_q && (wdata == KEY_SECOND))
        cnt_q <= CNT_W'(WIN_CYCLES);
      else if (unlock_wr || (rom_wr && win_open))
        cnt_q <= '0;
      else if (win_open)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_win_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WIN_CYCLES));
  assert_win_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(unlock_wr && wdata == KEY_SECOND && armed_q));
endmodule

// File: rtl/mmd_cfg.sv
module mmd_cfg
  import mmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  input  logic       win_open,
  output logic [2:0] rom_code,
  output logic [1:0] dme_code
);
  logic rom_take, dme_take;

  assign rom_take = wr && (sel == SEL_ROM) && win_open && (wdata[2:0] <= ROM_CODE_MAX);
  assign dme_take = wr && (sel == SEL_DME) && (wdata[1:0] != DME_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_code <= ROM_CODE_RESET;
      dme_code <= DME_OFF;
    end else begin
      if (rom_take) rom_code <= wdata[2:0];
      if (dme_take) dme_code <= wdata[1:0];
    end
  end

  assert_rom_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_code != $past(rom_code)) |-> $past(win_open && wr && sel == SEL_ROM));
  assert_rom_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_code <= ROM_CODE_MAX);
  assert_dme_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dme_code != DME_RSVD);
endmodule

// File: rtl/mmd_fetch_dec.sv
module mmd_fetch_dec
  import mmd_pkg::*;
#(
  parameter int KB_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_access_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        rom_code,
  output logic              f_int,
  output logic              f_ext,
  output logic              psen_n
);
  logic [ADDR_W:0] limit;

  always_comb begin
    limit  = rom_limit(rom_code, KB_SHIFT);
    f_int  = ext_access_n && ({1'b0, addr} < limit);
    f_ext  = !f_int;
    psen_n = f_int;
  end

  assert_int_in_rom_R1: assert property (@(posedge clk) disable iff (!rst_n)
    f_int |-> ({1'b0, addr} < ((ADDR_W+1)'(1) << (KB_SHIFT + 4))));
  assert_onehot_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({f_int, f_ext}));
endmodule

// File: rtl/mmd_data_dec.sv
module mmd_data_dec
  import mmd_pkg::*;
#(
  parameter int                SRAM_BYTES  = 1024,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        dme_code,
  input  logic [2:0]        lock_bits,
  output logic              d_sram,
  output logic              d_ext,
  output logic              d_lock,
  output logic              d_none,
  output logic [7:0]        lock_byte
);
  localparam logic [ADDR_W:0] SRAM_TOP = (ADDR_W+1)'(SRAM_BYTES);

  logic in_sram;

  always_comb begin
    in_sram = ({1'b0, addr} < SRAM_TOP);
    d_sram  = 1'b0;
    d_ext   = 1'b0;
    d_lock  = 1'b0;
    d_none  = 1'b0;
    unique case (dme_code)
      DME_SRAM_EXT: begin
        d_sram = in_sram;
        d_ext  = !in_sram;
      end
      DME_SRAM_STAT: begin
        d_sram = in_sram;
        d_lock = !in_sram && (addr == STATUS_ADDR);
        d_none = !in_sram && (addr != STATUS_ADDR);
      end
      default: d_ext = 1'b1;
    endcase
    lock_byte = d_lock ? {5'b0, lock_bits} : 8'h00;
  end

  assert_onehot_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({d_sram, d_ext, d_lock, d_none}));
  assert_no_ext_in_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dme_code == DME_SRAM_STAT) |-> !d_ext);
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int WIN_CYCLES = 3,
  parameter int KB_SHIFT   = 10,
  parameter int SRAM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_access_n,
  input  logic [15:0] fetch_addr,
  input  logic [15:0] data_addr,
  input  logic [2:0]  lock_bits,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic        fetch_int,
  output logic        fetch_ext,
  output logic        psen_n,
  output logic        data_sram,
  output logic        data_ext,
  output logic        data_lock,
  output logic        data_none,
  output logic [7:0]  lock_byte
);
  logic       win_open;
  logic [2:0] rom_code;
  logic [1:0] dme_code;

  mmd_timed_access #(.WIN_CYCLES(WIN_CYCLES)) u_ta (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .win_open(win_open)
  );

  mmd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .win_open(win_open), .rom_code(rom_code), .dme_code(dme_code)
  );

  mmd_fetch_dec #(.KB_SHIFT(KB_SHIFT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .ext_access_n(ext_access_n), .addr(fetch_addr),
    .rom_code(rom_code), .f_int(fetch_int), .f_ext(fetch_ext), .psen_n(psen_n)
  );

  mmd_data_dec #(.SRAM_BYTES(SRAM_BYTES)) u_data (
    .clk(clk), .rst_n(rst_n), .addr(data_addr), .dme_code(dme_code),
    .lock_bits(lock_bits), .d_sram(data_sram), .d_ext(data_ext),
    .d_lock(data_lock), .d_none(data_none), .lock_byte(lock_byte)
  );

  assert_extpin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_access_n |-> (fetch_ext && !psen_n));
  assert_reset_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dme_code == DME_OFF));
endmodule

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_access_n = 1'b1;
  logic [15:0] fetch_addr = '0, data_addr = '0;
  logic [2:0]  lock_bits = 3'b101;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'b11;
  logic [7:0]  reg_wdata = '0;
  logic        fetch_int, fetch_ext, psen_n;
  logic        data_sram, data_ext, data_lock, data_none;
  logic [7:0]  lock_byte;

  int checks = 0, errors = 0;
  int m_rom = 5, m_dme = 0, m_cnt = 0;
  bit m_arm = 0;

  always #4 clk = ~clk;

  mem_map_decoder dut (.*);

  function automatic int lim_of(int code);
    case (code)
      1: return 1024; 2: return 2048; 3: return 4096;
      4: return 8192; 5: return 16384; default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (rom=%0d dme=%0d fa=%h da=%h)",
               tag, act, exp, m_rom, m_dme, fetch_addr, data_addr);
    end
  endtask

  task automatic compare(input string ftag, input string dtag);
    logic fi; logic [3:0] dv; logic [7:0] lb;
    fi = ext_access_n && (int'(fetch_addr) < lim_of(m_rom));
    chk(ftag, {5'b0, fetch_int, fetch_ext, psen_n}, {5'b0, fi, !fi, fi});
    dv = 4'b0100; lb = 8'h00;
    if (m_dme == 1) dv = (data_addr < 16'h0400) ? 4'b1000 : 4'b0100;
    else if (m_dme == 3) begin
      if (data_addr < 16'h0400) dv = 4'b1000;
      else if (data_addr == 16'hFFFC) begin dv = 4'b0010; lb = {5'b0, lock_bits}; end
      else dv = 4'b0001;
    end
    chk(dtag, {4'b0, data_sram, data_ext, data_lock, data_none}, {4'b0, dv});
    chk("R7 lock_byte", lock_byte, lb);
  endtask

  // apply at negedge, model update at posedge, compare at next negedge
  task automatic cyc(input logic wr, input logic [1:0] sel, input logic [7:0] d,
                     input logic [15:0] fa, input logic [15:0] da, input logic ea_n,
                     input string ftag = "R1/R3 fetch", input string dtag = "R5/R6/R7 data");
    reg_wr = wr; reg_sel = sel; reg_wdata = d;
    fetch_addr = fa; data_addr = da; ext_access_n = ea_n;
    @(posedge clk);
    begin
      bit ul; ul = wr && sel == 2'b00;
      if (ul && m_arm && d == 8'h55) m_cnt = 3;
      else if (ul || (wr && sel == 2'b01 && m_cnt != 0)) begin
        if (!ul && d[2:0] <= 3'd5) m_rom = int'(d[2:0]);
        m_cnt = 0;
      end else if (m_cnt != 0) m_cnt--;
      if (wr && sel == 2'b10 && d[1:0] != 2'b10) m_dme = int'(d[1:0]);
      m_arm = ul && d == 8'hAA;
    end
    @(negedge clk);
    reg_wr = 1'b0;
    compare(ftag, dtag);
  endtask

  task automatic idle(input logic [15:0] fa, input logic [15:0] da, input string ftag = "R1/R3 fetch");
    cyc(1'b0, 2'b11, 8'h00, fa, da, 1'b1, ftag);
  endtask

  task automatic unlock_write(input logic [7:0] code);
    cyc(1'b1, 2'b00, 8'hAA, 16'h0, 16'h0, 1'b1);
    cyc(1'b1, 2'b00, 8'h55, 16'h0, 16'h0, 1'b1);
    cyc(1'b1, 2'b01, code, 16'h0, 16'h0, 1'b1);
  endtask

  function automatic logic [15:0] pick();
    logic [15:0] c [13] = '{16'h0000, 16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h0FFF,
                            16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'hFFFC, 16'hFFFD};
    int r; r = $urandom_range(0, 16);
    return (r < 13) ? c[r] : 16'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset map
    idle(16'h3FFF, 16'h0000, "R2 reset fetch 3FFF");
    idle(16'h4000, 16'h0400, "R2 reset fetch 4000");
    // R5 default external
    cyc(1'b0, 2'b11, 0, 16'h0, 16'hFFFC, 1'b1, "R1", "R5 dme00");
    // R4 ext pin low
    cyc(1'b0, 2'b11, 0, 16'h0000, 16'h0, 1'b0, "R4 ea low");
    // R9 unprotected ROM write ignored
    cyc(1'b1, 2'b01, 8'h03, 16'h2000, 16'h0, 1'b1, "R9 no unlock");
    idle(16'h2000, 16'h0, "R9 no unlock");
    // R9 unlock then 4 KB
    unlock_write(8'h03);
    idle(16'h0FFF, 16'h0, "R1 4K in");
    idle(16'h1000, 16'h0, "R3 4K out");
    // R9 window expiry: write on 4th cycle after 55h is ignored
    cyc(1'b1, 2'b00, 8'hAA, 0, 0, 1'b1);
    cyc(1'b1, 2'b00, 8'h55, 0, 0, 1'b1);
    idle(0, 0); idle(0, 0); idle(0, 0);
    cyc(1'b1, 2'b01, 8'h01, 16'h0800, 0, 1'b1, "R9 expired");
    idle(16'h0800, 0, "R9 expired keep 4K");
    // R9 gap between keys
    cyc(1'b1, 2'b00, 8'hAA, 0, 0, 1'b1);
    idle(0, 0);
    cyc(1'b1, 2'b00, 8'h55, 0, 0, 1'b1);
    cyc(1'b1, 2'b01, 8'h00, 16'h0000, 0, 1'b1, "R9 gap");
    idle(16'h0000, 0, "R9 gap keep");
    // R9 last window cycle accepted
    cyc(1'b1, 2'b00, 8'hAA, 0, 0, 1'b1);
    cyc(1'b1, 2'b00, 8'h55, 0, 0, 1'b1);
    idle(0, 0); idle(0, 0);
    cyc(1'b1, 2'b01, 8'h00, 16'h0000, 0, 1'b1, "R9 3rd cycle");
    idle(16'h0000, 0, "R1 0K ext");
    // R10 reserved codes
    unlock_write(8'h06);
    idle(16'h0000, 0, "R10 code6 ignored");
    unlock_write(8'h07);
    cyc(1'b1, 2'b01, 8'h05, 16'h0000, 0, 1'b1, "R10 window closed");
    idle(16'h0000, 0, "R10 keep");
    // R1 each code
    for (int c = 1; c <= 5; c++) begin
      unlock_write(8'(c));
      idle(16'(lim_of(c) - 1), 0, "R1 limit-1");
      idle(16'(lim_of(c)), 0, "R3 limit");
    end
    // R6 / R7 / R8
    cyc(1'b1, 2'b10, 8'h01, 0, 16'h03FF, 1'b1, "R1", "R6 3FF");
    idle(0, 16'h0400);
    cyc(1'b1, 2'b10, 8'h02, 0, 16'h0000, 1'b1, "R1", "R8 rsvd ignored");
    cyc(1'b1, 2'b10, 8'h03, 0, 16'hFFFC, 1'b1, "R1", "R7 status");
    lock_bits = 3'b010;
    idle(0, 16'hFFFB); idle(0, 16'hFFFC); idle(0, 16'hFFFD); idle(0, 16'h03FF);
    // random phase: R11 and all
    for (int i = 0; i < 3000; i++) begin
      int k; k = $urandom_range(0, 9);
      lock_bits = 3'($urandom);
      if (k == 0) unlock_write(8'($urandom_range(0, 7)));
      else if (k == 1) cyc(1'b1, 2'b10, 8'($urandom_range(0, 3)), pick(), pick(), 1'b1, "R11 fetch", "R11 data");
      else if (k == 2) cyc(1'b1, 2'($urandom), 8'($urandom), pick(), pick(), 1'b1, "R11 fetch", "R11 data");
      else cyc(1'b0, 2'b11, 0, pick(), pick(), (k != 3), "R11 fetch", "R11 data");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule